// File: doc/BRIEF.md
# PHY Management Port with Register Model

This block is the management side of an Ethernet MAC: two 16-bit software registers, an address register and a data register, give access to the registers of one or more PHYs. The PHYs are modelled inside the block. Software first loads the data register when it writes, then writes the address register with the busy bit set. That write names the PHY, the register and the direction. After a fixed number of cycles the access completes. A read leaves the PHY register value in the data register. A write stores the data register into the PHY register. Busy then drops.

PHY 0 holds the reset values of a gigabit copper PHY and follows an external link-up input. Writes to its control register behave like a PHY that finishes autonegotiation at once. The serial clock and data line timing is left out. In its place the access has a fixed latency, so software that polls busy sees the usual handshake.

Top module: `phy_mgmt_port`

## Requirements
- R1: After reset the address register and the data register both read 0x0000, so busy (address bit 0) is low.
- R2: The address register fields are: busy at bit 0, write-select at bit 1 (1 = write, 0 = read), PHY register number at bits 10:6 and PHY address at bits 15:11. A write with bit 0 set starts an access, and busy then stays high for exactly LATENCY cycles. After the access the register keeps the written value with bit 0 cleared. A write with bit 0 clear only stores the value and starts no access.
- R3: A read access copies the selected 16-bit PHY register into the data register. A write access stores the data register into the selected PHY register.
- R4: While busy is high, writes to the address register and to the data register are ignored.
- R5: At reset PHY 0 holds these values: register 0 = 0x1140 (autonegotiation enable, full duplex, 1000 Mb/s), 1 = 0x790D, 2 = 0x0362, 3 = 0x5E6A, 4 = 0x01E1, 5 = 0x45E1, 7 = 0x2001, 15 = 0x3000.
- R6: A write access to register 0 stores the value with bit 15 (reset) and bit 9 (restart autonegotiation) forced to zero.
- R7: If a write access to register 0 has bit 12 (autonegotiation enable) set while bit 5 (autonegotiation complete) of register 1 is clear, bit 5 of register 1 is set and register 5 is cleared. In every other case a register 0 write leaves registers 1 and 5 unchanged.
- R8: When link_up_i rises, bits 2 (link) and 5 (autonegotiation complete) of PHY 0 register 1 are set. When it falls, both bits are cleared. No other bits change.
- R9: PHYs 1 to NUM_PHYS-1 have their own storage, which resets to zero. A PHY address of NUM_PHYS or above reads zero, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Software register write strobe |
| reg_sel_i | input | 1 | Target register: 0 = address, 1 = data |
| reg_wdata_i | input | 16 | Software write data |
| link_up_i | input | 1 | External link state for PHY 0 |
| addr_reg_o | output | 16 | Address register contents (bit 0 = busy) |
| data_reg_o | output | 16 | Data register contents |

## Verification
Assertions check three things on every cycle: each busy period lasts exactly LATENCY cycles, the PHY and register fields do not change when busy clears, and the address and data registers refuse software writes during an access. Only the bench can show the PHY register contents, because they are reached only through completed read accesses. This covers the reset values, the masking of control register bits, the autonegotiation side effects in their set and not-set cases, the effect of link transitions, and separate storage for each PHY. The bench checks these with a scoreboard of expected read results.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DATA_W = 16;
  localparam int FLD_W  = 5;

  localparam logic SEL_ADDR = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  localparam int REG_CTL  = 0;
  localparam int REG_STAT = 1;
  localparam int REG_LPA  = 5;

  localparam int CTL_RESET_BIT   = 15;
  localparam int CTL_AN_EN_BIT   = 12;
  localparam int CTL_AN_RST_BIT  = 9;
  localparam int STAT_LINK_BIT   = 2;
  localparam int STAT_AN_OK_BIT  = 5;

  function automatic logic [DATA_W-1:0] phy_reset_val(int idx);
    case (idx)
      0:  return 16'h1140;
      1:  return 16'h790D;
      2:  return 16'h0362;
      3:  return 16'h5E6A;
      4:  return 16'h01E1;
      5:  return 16'h45E1;
      6:  return 16'h0065;
      7:  return 16'h2001;
      9:  return 16'h0200;
      10: return 16'h0800;
      15: return 16'h3000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              go_o,
  output logic              go_wr_o,
  output logic [FLD_W-1:0]  phy_o,
  output logic [FLD_W-1:0]  reg_o
);
  localparam int CW = $clog2(LATENCY + 1);

  logic [DATA_W-1:0] addr_q, data_q;
  logic [CW-1:0]     cnt_q;
  logic              busy;

  assign busy    = addr_q[0];
  assign go_o    = busy && (cnt_q == '0);
  assign go_wr_o = addr_q[1];
  assign phy_o   = addr_q[15:11];
  assign reg_o   = addr_q[10:6];
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else if (busy) begin
      // software writes are dropped for the whole access
      if (go_o) begin
        addr_q[0] <= 1'b0;
        if (!addr_q[1]) data_q <= rd_data_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (wr_i) begin
      if (sel_i == SEL_ADDR) begin
        addr_q <= wdata_i;
        cnt_q  <= CW'(LATENCY - 1);
      end else begin
        data_q <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_mgmt_pkg::*;
#(
  parameter int NUM_REGS     = 32,
  parameter bit USE_DEFAULTS = 1'b1,
  parameter bit TRACK_LINK   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [FLD_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              link_evt_i,
  input  logic              link_up_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [DATA_W-1:0] CTL_CLR_MASK =
    DATA_W'((1 << CTL_RESET_BIT) | (1 << CTL_AN_RST_BIT));

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] regs_d [NUM_REGS];
  logic              in_range;

  assign in_range = (32'(reg_i) < NUM_REGS);

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (32'(reg_i) == i) rd_data_o = regs_q[i];
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regs_d[i] = regs_q[i];
    if (wr_i && in_range) begin
      if (32'(reg_i) == REG_CTL) begin
        regs_d[REG_CTL] = wdata_i & ~CTL_CLR_MASK;
        if (wdata_i[CTL_AN_EN_BIT] && !regs_q[REG_STAT][STAT_AN_OK_BIT]) begin
          regs_d[REG_STAT][STAT_AN_OK_BIT] = 1'b1;
          regs_d[REG_LPA] = '0;
        end
      end else begin
        for (int i = 0; i < NUM_REGS; i++)
          if (32'(reg_i) == i) regs_d[i] = wdata_i;
      end
    end
    if (TRACK_LINK && link_evt_i) begin
      regs_d[REG_STAT][STAT_LINK_BIT]  = link_up_i;
      regs_d[REG_STAT][STAT_AN_OK_BIT] = link_up_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++)
        regs_q[i] <= USE_DEFAULTS ? phy_reset_val(i) : '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
    end
  end
endmodule

// File: rtl/phy_mgmt_port.sv
module phy_mgmt_port
  import phy_mgmt_pkg::*;
#(
  parameter int NUM_PHYS = 4,
  parameter int NUM_REGS = 32,
  parameter int LATENCY  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_sel_i,
  input  logic [15:0] reg_wdata_i,
  input  logic        link_up_i,
  output logic [15:0] addr_reg_o,
  output logic [15:0] data_reg_o
);
  logic              go, go_wr, link_q, link_evt;
  logic [FLD_W-1:0]  phy_sel, reg_sel;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] bank_rd [NUM_PHYS];

  phy_mgmt_regs #(.LATENCY(LATENCY)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .rd_data_i (rd_mux),
    .addr_o    (addr_reg_o),
    .data_o    (data_reg_o),
    .go_o      (go),
    .go_wr_o   (go_wr),
    .phy_o     (phy_sel),
    .reg_o     (reg_sel)
  );

  // link events are edges of the input; the reset value assumes link up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_q <= 1'b1;
    else         link_q <= link_up_i;
  end
  assign link_evt = link_up_i ^ link_q;

  for (genvar g = 0; g < NUM_PHYS; g++) begin : gen_bank
    phy_reg_bank #(
      .NUM_REGS     (NUM_REGS),
      .USE_DEFAULTS (g == 0),
      .TRACK_LINK   (g == 0)
    ) bank_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (go && go_wr && (32'(phy_sel) == g)),
      .reg_i      (reg_sel),
      .wdata_i    (data_reg_o),
      .link_evt_i (link_evt),
      .link_up_i  (link_up_i),
      .rd_data_o  (bank_rd[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_PHYS; g++)
      if (32'(phy_sel) == g) rd_mux = bank_rd[g];
  end
endmodule

// File: rtl/phy_mgmt_port_chk.sv
module phy_mgmt_port_chk #(
  parameter int LATENCY = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_i,
  input logic        reg_sel_i,
  input logic [15:0] addr_reg_o,
  input logic [15:0] data_reg_o
);
  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= 0;
    else if (addr_reg_o[0]) run_q <= run_q + 1;
    else                    run_q <= 0;
  end

  a_r2_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_reg_o[0] && run_q != 0) |-> run_q == LATENCY);

  a_r2_busy_never_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= LATENCY);

  a_r2_fields_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(addr_reg_o[0]) |-> addr_reg_o[15:1] == $past(addr_reg_o[15:1]));

  a_r4_addr_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_reg_o[0] && reg_wr_i && !reg_sel_i) |=> $stable(addr_reg_o[15:1]));

  a_r4_data_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_reg_o[0] && addr_reg_o[1]) |=> $stable(data_reg_o));
endmodule

bind phy_mgmt_port phy_mgmt_port_chk #(.LATENCY(LATENCY)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_sel_i  (reg_sel_i),
  .addr_reg_o (addr_reg_o),
  .data_reg_o (data_reg_o)
);

// File: tb/phy_mgmt_port_tb_top.sv
module phy_mgmt_port_tb_top;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] wdata = '0;
  logic        link = 1'b1;
  logic [15:0] addr_o, data_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  phy_mgmt_port #(.NUM_PHYS(4), .NUM_REGS(32), .LATENCY(LAT)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (wr),
    .reg_sel_i   (sel),
    .reg_wdata_i (wdata),
    .link_up_i   (link),
    .addr_reg_o  (addr_o),
    .data_reg_o  (data_o)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: on each read completion pop and compare
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_busy && !addr_o[0] && !addr_o[1]) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3: unexpected read completion, data %h", data_o);
      end else begin
        chk(data_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
    prev_busy = addr_o[0];
  end

  function automatic logic [15:0] aw(input int pa, input int ra, input bit w, input bit b);
    return {5'(pa), 5'(ra), 4'b0, w, b};
  endfunction

  task automatic wr_reg(input logic s, input logic [15:0] v);
    @(negedge clk);
    wr = 1'b1; sel = s; wdata = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (addr_o[0]) @(negedge clk);
  endtask

  task automatic phy_wr(input int pa, input int ra, input logic [15:0] v);
    wr_reg(1'b1, v);
    wr_reg(1'b0, aw(pa, ra, 1'b1, 1'b1));
    wait_idle();
  endtask

  task automatic phy_rd(input int pa, input int ra, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    wr_reg(1'b0, aw(pa, ra, 1'b0, 1'b1));
    wait_idle();
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_o, 16'h0000, "R1 addr reset");
    chk(data_o, 16'h0000, "R1 data reset");

    // R5 PHY 0 reset contents
    phy_rd(0, 0,  16'h1140, "R5 reg0");
    phy_rd(0, 1,  16'h790D, "R5 reg1");
    phy_rd(0, 2,  16'h0362, "R5 reg2");
    phy_rd(0, 3,  16'h5E6A, "R5 reg3");
    phy_rd(0, 4,  16'h01E1, "R5 reg4");
    phy_rd(0, 5,  16'h45E1, "R5 reg5");
    phy_rd(0, 7,  16'h2001, "R5 reg7");
    phy_rd(0, 15, 16'h3000, "R5 reg15");

    // R2 busy length and kept fields
    begin
      int n = 0;
      exp_q.push_back(16'h0362); tag_q.push_back("R3 read reg2");
      wr_reg(1'b0, aw(0, 2, 1'b0, 1'b1));
      while (addr_o[0]) begin n++; @(negedge clk); end
      chk(16'(n), 16'(LAT), "R2 busy cycles");
      chk(addr_o, aw(0, 2, 1'b0, 1'b0), "R2 addr kept busy cleared");
    end

    // R2 write without busy starts nothing
    wr_reg(1'b0, 16'h0844);
    chk(addr_o, 16'h0844, "R2 idle addr store");
    @(negedge clk);
    chk({15'b0, addr_o[0]}, 16'h0000, "R2 no access started");
    chk(data_o, 16'h0362, "R2 data untouched");

    // R3 write then read back
    phy_wr(0, 4, 16'h1234);
    phy_rd(0, 4, 16'h1234, "R3 write readback");

    // R4 writes ignored during busy
    wr_reg(1'b1, 16'hA5A5);
    wr_reg(1'b0, aw(0, 6, 1'b1, 1'b1));
    wr_reg(1'b0, aw(1, 9, 1'b0, 1'b1));
    wr_reg(1'b1, 16'hFFFF);
    wait_idle();
    chk(addr_o, aw(0, 6, 1'b1, 1'b0), "R4 addr write ignored");
    chk(data_o, 16'hA5A5, "R4 data write ignored");
    phy_rd(0, 6, 16'hA5A5, "R4 stored payload");

    // R9 per-PHY storage and out-of-range PHY
    phy_rd(1, 3, 16'h0000, "R9 phy1 zero reset");
    phy_wr(1, 3, 16'hBEEF);
    phy_rd(1, 3, 16'hBEEF, "R9 phy1 readback");
    phy_rd(0, 3, 16'h5E6A, "R9 phy0 untouched");
    phy_wr(20, 4, 16'h5555);
    phy_rd(20, 4, 16'h0000, "R9 absent phy reads zero");

    // R6 R7 control write with autoneg enable, autoneg incomplete
    phy_wr(0, 0, 16'hB340);
    phy_rd(0, 0, 16'h3140, "R6 reset and restart cleared");
    phy_rd(0, 1, 16'h792D, "R7 an complete set");
    phy_rd(0, 5, 16'h0000, "R7 partner ability cleared");

    // R8 link down
    set_link(1'b0);
    phy_rd(0, 1, 16'h7909, "R8 link down clears bits");

    // R7 no autoneg enable: no side effect
    phy_wr(0, 5, 16'h1111);
    phy_wr(0, 0, 16'h0140);
    phy_rd(0, 0, 16'h0140, "R6 plain control write");
    phy_rd(0, 1, 16'h7909, "R7 status unchanged no enable");
    phy_rd(0, 5, 16'h1111, "R7 partner kept no enable");

    // R8 link up
    set_link(1'b1);
    phy_rd(0, 1, 16'h792D, "R8 link up sets bits");

    // R7 autoneg already complete: no side effect
    phy_wr(0, 0, 16'h1000);
    phy_rd(0, 5, 16'h1111, "R7 partner kept when complete");

    // R7 link down then enable: status bit 5 set, link bit stays clear
    set_link(1'b0);
    phy_wr(0, 0, 16'h1200);
    phy_rd(0, 0, 16'h1000, "R6 restart cleared");
    phy_rd(0, 1, 16'h7929, "R7 complete set with link down");
    phy_rd(0, 5, 16'h0000, "R7 partner cleared again");

    repeat (2) @(negedge clk);
    chk(16'(exp_q.size()), 16'h0000, "R3 all reads completed");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule